// File: doc/BRIEF.md
# Bitplane Fetch Phase Placement

This block places the bitplanes of one display row for a bitplane shifter. At the start of each line it takes five inputs: the position where data fetch starts, the resolution mode, the fetch width mode, the number of active planes and the two playfield scroll values. From these it computes how far the row origin moves left, and a signed delay in native pixels for each plane.

A fetch that starts off the reload grid normally arrives too late for its own slot, so it waits for the next one. When a playfield's scroll delay is at least as large as that lateness, the planes of that playfield can still use the earlier slot, which is one whole fetch unit sooner. In that case the row origin moves left by one fetch unit. Every plane is then measured again against the moved origin. The plane that caught the early slot keeps its scroll as its delay. A plane that still waits gets one extra fetch unit of delay.

A sampling stage then applies these delays. It reads one word of shifted data per plane at the current native pixel position and produces a registered colour index. The line values are captured only on a line-load strobe and hold until the next one.

Top module: `fpp_phase_place`

## Requirements
- R1: While reset is held, and at the first edge after it, the row advance, every plane delay and the colour index are all zero.
- R2: Row advance and plane delays change only on a clock edge where `line_load` is high. Input changes without the strobe have no effect on them.
- R3: The reload grid period is 8 colour clocks in lo-res (`res_mode`=0), 4 in hi-res (1) and 2 in super-hi-res (2). Code 3 behaves as lo-res. The phase is `fetch_start` modulo that period. A phase of 0 never gives an advance.
- R4: Lateness is the phase times 2, 4 or 8 native pixels per colour clock (lo-res, hi-res, super-hi-res). A playfield's advance is 16 native pixels when the lateness is at most its scroll, and 0 otherwise. The row advance output is always either 0 or 16.
- R5: No advance is produced unless `single_word` (single-word fetch mode) is high.
- R6: The row advance equals the playfield 1 advance. When `plane_cnt` is 2 or more, it is the larger of the two playfield advances.
- R7: Planes 0, 2 and 4 use the playfield 1 scroll; planes 1, 3 and 5 use the playfield 2 scroll. Each plane's delay is its scroll, plus the row advance, minus the advance computed for its own scroll. The delay is a two's-complement value of 6 bits at `plane_delay[6p +: 6]` and may be negative.
- R8: For plane p, the fetch position is the pixel position minus the plane's delay. The colour bit is bit (15 - fetch position) of `plane_words[16p +: 16]`, so the MSB is fetch pixel 0, when the fetch position is in the range 0 to 15. Otherwise the bit is 0, which covers the case where the delay exceeds the pixel position.
- R9: Colour bits of planes at or above the latched plane count are 0.
- R10: `colour_idx` is registered. It reflects `pix_x` and `plane_words` from the edge after they are presented, and it does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_load | input | 1 | Latch this line's placement inputs |
| fetch_start | input | 8 | Fetch start position in colour clocks |
| res_mode | input | 2 | 0 lo-res, 1 hi-res, 2 super-hi-res, 3 as lo-res |
| single_word | input | 1 | High in single-word fetch mode |
| plane_cnt | input | 3 | Number of active planes (0 to 6) |
| pf1_scroll | input | 4 | Playfield 1 scroll in native pixels |
| pf2_scroll | input | 4 | Playfield 2 scroll in native pixels |
| pix_x | input | 10 | Native pixel position to sample |
| plane_words | input | 96 | One 16-bit data word per plane |
| row_advance | output | 5 | Row origin advance in native pixels |
| plane_delay | output | 36 | Signed 6-bit delay per plane |
| colour_idx | output | 6 | Sampled colour index, one bit per plane |

## Verification
The checks on latched values assume three things about the inputs: `line_load` is sampled as a clean single-cycle strobe, the scroll inputs are stable while it is high, and `plane_cnt` never exceeds the number of planes. The equal-scroll property also assumes that the module has at least two planes. The stimulus drives every input on the falling edge and pulses `line_load` for exactly one cycle. It keeps `plane_cnt` between 1 and 6, so every latched value comes from one coherent set of inputs.

// File: rtl/fpp_pkg.sv
// Shared definitions for the fetch phase placement block.
// Assumes resolution code 3 is unused and treats it as lo-res.
package fpp_pkg;

    typedef enum logic [1:0] {
        RES_LO  = 2'd0,
        RES_HI  = 2'd1,
        RES_SH  = 2'd2,
        RES_RSV = 2'd3
    } res_e;

    // Shift amount applied to grid period (right) and pixel rate (left).
    function automatic logic [1:0] res_shift(input logic [1:0] res_code);
        return (res_code == RES_RSV) ? 2'd0 : res_code;
    endfunction

endpackage

// File: rtl/fpp_phase_unit.sv
// Decides for one playfield whether its scroll covers the fetch lateness.
// Assumes GRID_LORES is a power of two and LORES_RATE is lo-res px per cck.
module fpp_phase_unit #(
    parameter int START_W    = 8,
    parameter int SCROLL_W   = 4,
    parameter int GRID_LORES = 8,
    parameter int LORES_RATE = 2
) (
    input  logic [START_W-1:0]  fetch_start,
    input  logic [1:0]          res_mode,
    input  logic                single_word,
    input  logic [SCROLL_W-1:0] scroll,
    output logic                adv_hit
);
    import fpp_pkg::*;

    localparam int ADV_MAX = GRID_LORES * LORES_RATE;
    localparam int LAT_W   = $clog2(ADV_MAX) + 1;

    logic [1:0]         sh;
    logic [START_W-1:0] period;
    logic [START_W-1:0] phase;
    logic [LAT_W-1:0]   lateness;

    // Grid phase, lateness in native px and the covered decision.
    always_comb begin
        sh       = res_shift(res_mode);
        period   = START_W'(GRID_LORES >> sh);
        phase    = fetch_start & (period - 1'b1);
        lateness = LAT_W'(int'(phase) * (LORES_RATE << sh));
        adv_hit  = single_word && (phase != '0) && (int'(lateness) <= int'(scroll));
    end

endmodule

// File: rtl/fpp_delay_calc.sv
// Forms the row advance and the signed per-plane delays from the two
// playfield decisions. Even planes belong to playfield 1, odd to playfield 2.
module fpp_delay_calc #(
    parameter int NUM_PLANES = 6,
    parameter int SCROLL_W   = 4,
    parameter int PCNT_W     = 3,
    parameter int ADV_MAX    = 16,
    parameter int ADV_W      = 5,
    parameter int DELAY_W    = 6
) (
    input  logic [SCROLL_W-1:0]      pf1_scroll,
    input  logic [SCROLL_W-1:0]      pf2_scroll,
    input  logic                     pf1_hit,
    input  logic                     pf2_hit,
    input  logic [PCNT_W-1:0]        plane_cnt,
    output logic [ADV_W-1:0]         row_adv,
    output logic signed [DELAY_W-1:0] delay [NUM_PLANES]
);
    logic row_hit;

    // Row advance: playfield 1, or the larger of both with two or more planes.
    always_comb begin
        row_hit = pf1_hit | ((int'(plane_cnt) >= 2) & pf2_hit);
        row_adv = row_hit ? ADV_W'(ADV_MAX) : '0;
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        localparam bit ODD = (p % 2) == 1;
        logic [SCROLL_W-1:0] scr;
        logic                own_hit;

        // Rebase this plane's scroll against the row origin.
        always_comb begin
            scr      = ODD ? pf2_scroll : pf1_scroll;
            own_hit  = ODD ? pf2_hit : pf1_hit;
            delay[p] = DELAY_W'(int'(scr) + (row_hit ? ADV_MAX : 0) - (own_hit ? ADV_MAX : 0));
        end
    end

endmodule

// File: rtl/fpp_line_latch.sv
// Holds the per-line placement results between line-load strobes.
module fpp_line_latch #(
    parameter int NUM_PLANES = 6,
    parameter int PCNT_W     = 3,
    parameter int ADV_W      = 5,
    parameter int DELAY_W    = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_load,
    input  logic [ADV_W-1:0]          row_adv_d,
    input  logic signed [DELAY_W-1:0] delay_d [NUM_PLANES],
    input  logic [PCNT_W-1:0]         plane_cnt_d,
    output logic [ADV_W-1:0]          row_adv_q,
    output logic signed [DELAY_W-1:0] delay_q [NUM_PLANES],
    output logic [PCNT_W-1:0]         plane_cnt_q
);
    // Capture advance and plane count once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_adv_q   <= '0;
            plane_cnt_q <= '0;
        end else if (line_load) begin
            row_adv_q   <= row_adv_d;
            plane_cnt_q <= plane_cnt_d;
        end
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_hold
        // Capture this plane's delay once per line.
        always_ff @(posedge clk) begin
            if (!rst_n)         delay_q[p] <= '0;
            else if (line_load) delay_q[p] <= delay_d[p];
        end
    end

endmodule

// File: rtl/fpp_delay_sampler.sv
// Applies each plane's delay to its data word and registers the colour index.
// Assumes word MSB is fetch pixel 0 and pix_x counts native pixels.
module fpp_delay_sampler #(
    parameter int NUM_PLANES = 6,
    parameter int PCNT_W     = 3,
    parameter int DELAY_W    = 6,
    parameter int PIX_W      = 10,
    parameter int WORD_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [DELAY_W-1:0] delay_q [NUM_PLANES],
    input  logic [PCNT_W-1:0]         plane_cnt_q,
    input  logic [PIX_W-1:0]          pix_x,
    input  logic [NUM_PLANES*WORD_W-1:0] plane_words,
    output logic [NUM_PLANES-1:0]     colour_idx
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [NUM_PLANES-1:0] bit_d;

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_tap
        int               fx;
        logic [IDX_W-1:0] bidx;
        logic [WORD_W-1:0] word;

        // Select this plane's bit at the delayed fetch position.
        always_comb begin
            word = plane_words[p*WORD_W +: WORD_W];
            fx   = int'(pix_x) - int'(delay_q[p]);
            bidx = IDX_W'(WORD_W - 1 - fx);
            if ((int'(plane_cnt_q) > p) && (fx >= 0) && (fx < WORD_W))
                bit_d[p] = word[bidx];
            else
                bit_d[p] = 1'b0;
        end
    end

    // Register the assembled colour index.
    always_ff @(posedge clk) begin
        if (!rst_n) colour_idx <= '0;
        else        colour_idx <= bit_d;
    end

endmodule

// File: rtl/fpp_phase_place.sv
// Top of the fetch phase placement block: two playfield phase units,
// delay formation, per-line latch and the delay sampler.
// Assumes line_load is a single-cycle strobe at the start of each line.
module fpp_phase_place #(
    parameter int NUM_PLANES = 6,
    parameter int START_W    = 8,
    parameter int SCROLL_W   = 4,
    parameter int GRID_LORES = 8,
    parameter int LORES_RATE = 2,
    parameter int PIX_W      = 10,
    parameter int WORD_W     = 16,
    localparam int ADV_MAX   = GRID_LORES * LORES_RATE,
    localparam int ADV_W     = $clog2(ADV_MAX + 1),
    localparam int SCROLL_MAX = (1 << SCROLL_W) - 1,
    localparam int DELAY_W   = $clog2(SCROLL_MAX + ADV_MAX + 1) + 1,
    localparam int PCNT_W    = $clog2(NUM_PLANES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_load,
    input  logic [START_W-1:0]            fetch_start,
    input  logic [1:0]                    res_mode,
    input  logic                          single_word,
    input  logic [PCNT_W-1:0]             plane_cnt,
    input  logic [SCROLL_W-1:0]           pf1_scroll,
    input  logic [SCROLL_W-1:0]           pf2_scroll,
    input  logic [PIX_W-1:0]              pix_x,
    input  logic [NUM_PLANES*WORD_W-1:0]  plane_words,
    output logic [ADV_W-1:0]              row_advance,
    output logic [NUM_PLANES*DELAY_W-1:0] plane_delay,
    output logic [NUM_PLANES-1:0]         colour_idx
);
    logic                      hit [2];
    logic [ADV_W-1:0]          row_adv_d;
    logic signed [DELAY_W-1:0] delay_d [NUM_PLANES];
    logic signed [DELAY_W-1:0] delay_q [NUM_PLANES];
    logic [PCNT_W-1:0]         plane_cnt_q;

    for (genvar f = 0; f < 2; f++) begin : g_pf
        fpp_phase_unit #(
            .START_W(START_W), .SCROLL_W(SCROLL_W),
            .GRID_LORES(GRID_LORES), .LORES_RATE(LORES_RATE)
        ) u_phase (
            .fetch_start(fetch_start),
            .res_mode   (res_mode),
            .single_word(single_word),
            .scroll     ((f == 0) ? pf1_scroll : pf2_scroll),
            .adv_hit    (hit[f])
        );
    end

    fpp_delay_calc #(
        .NUM_PLANES(NUM_PLANES), .SCROLL_W(SCROLL_W), .PCNT_W(PCNT_W),
        .ADV_MAX(ADV_MAX), .ADV_W(ADV_W), .DELAY_W(DELAY_W)
    ) u_calc (
        .pf1_scroll(pf1_scroll),
        .pf2_scroll(pf2_scroll),
        .pf1_hit   (hit[0]),
        .pf2_hit   (hit[1]),
        .plane_cnt (plane_cnt),
        .row_adv   (row_adv_d),
        .delay     (delay_d)
    );

    fpp_line_latch #(
        .NUM_PLANES(NUM_PLANES), .PCNT_W(PCNT_W),
        .ADV_W(ADV_W), .DELAY_W(DELAY_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_load  (line_load),
        .row_adv_d  (row_adv_d),
        .delay_d    (delay_d),
        .plane_cnt_d(plane_cnt),
        .row_adv_q  (row_advance),
        .delay_q    (delay_q),
        .plane_cnt_q(plane_cnt_q)
    );

    fpp_delay_sampler #(
        .NUM_PLANES(NUM_PLANES), .PCNT_W(PCNT_W), .DELAY_W(DELAY_W),
        .PIX_W(PIX_W), .WORD_W(WORD_W)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_q    (delay_q),
        .plane_cnt_q(plane_cnt_q),
        .pix_x      (pix_x),
        .plane_words(plane_words),
        .colour_idx (colour_idx)
    );

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_out
        // Flatten the latched delays onto the output bus.
        assign plane_delay[p*DELAY_W +: DELAY_W] = delay_q[p];
    end

endmodule

// File: rtl/fpp_phase_place_chk.sv
// Property checker for fpp_phase_place, attached by bind.
// Assumes at least two planes and a clean single-cycle line_load.
module fpp_phase_place_chk #(
    parameter int NUM_PLANES = 6,
    parameter int START_W    = 8,
    parameter int SCROLL_W   = 4,
    parameter int GRID_LORES = 8,
    parameter int LORES_RATE = 2,
    parameter int ADV_W      = 5,
    parameter int DELAY_W    = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          line_load,
    input logic [START_W-1:0]            fetch_start,
    input logic                          single_word,
    input logic [SCROLL_W-1:0]           pf1_scroll,
    input logic [SCROLL_W-1:0]           pf2_scroll,
    input logic [ADV_W-1:0]              row_advance,
    input logic [NUM_PLANES*DELAY_W-1:0] plane_delay,
    input logic [NUM_PLANES-1:0]         colour_idx
);
    localparam int ADV_MAX = GRID_LORES * LORES_RATE;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (row_advance == '0 && plane_delay == '0 && colour_idx == '0)); // R1
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_load |=> ($stable(row_advance) && $stable(plane_delay))); // R2
    AST_GRID_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load && (int'(fetch_start) % GRID_LORES == 0)) |=> row_advance == '0); // R3
    AST_ADV_TWO_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (row_advance == '0) || (int'(row_advance) == ADV_MAX)); // R4
    AST_SINGLE_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load && !single_word) |=> row_advance == '0); // R5
    AST_EQUAL_SCROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load && pf1_scroll == pf2_scroll) |=>
        plane_delay[0 +: DELAY_W] == plane_delay[DELAY_W +: DELAY_W]); // R7

endmodule

bind fpp_phase_place fpp_phase_place_chk #(
    .NUM_PLANES(NUM_PLANES), .START_W(START_W), .SCROLL_W(SCROLL_W),
    .GRID_LORES(GRID_LORES), .LORES_RATE(LORES_RATE),
    .ADV_W(ADV_W), .DELAY_W(DELAY_W)
) u_chk (.*);

// File: tb/fpp_phase_place_bench.sv
// Self-checking bench: a vector table of line configurations, then directed
// reset, hold, sampler and timing tests.
module fpp_phase_place_bench;

    localparam int NP = 6;
    localparam int DW = 6;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_load = 1'b0;
    logic [7:0]    fetch_start = '0;
    logic [1:0]    res_mode = '0;
    logic          single_word = 1'b0;
    logic [2:0]    plane_cnt = '0;
    logic [3:0]    pf1_scroll = '0;
    logic [3:0]    pf2_scroll = '0;
    logic [9:0]    pix_x = '0;
    logic [NP*WW-1:0] plane_words = '0;
    logic [4:0]    row_advance;
    logic [NP*DW-1:0] plane_delay;
    logic [NP-1:0] colour_idx;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    fpp_phase_place u_fpp_phase_place (
        .clk(clk), .rst_n(rst_n), .line_load(line_load),
        .fetch_start(fetch_start), .res_mode(res_mode), .single_word(single_word),
        .plane_cnt(plane_cnt), .pf1_scroll(pf1_scroll), .pf2_scroll(pf2_scroll),
        .pix_x(pix_x), .plane_words(plane_words),
        .row_advance(row_advance), .plane_delay(plane_delay), .colour_idx(colour_idx)
    );

    typedef struct packed {
        logic [7:0]        start;
        logic [1:0]        res;
        logic              sw;
        logic [2:0]        pc;
        logic [3:0]        s1;
        logic [3:0]        s2;
        logic [4:0]        adv;
        logic signed [5:0] d0;
        logic signed [5:0] d1;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h66, 2'd0, 1'b1, 3'd2, 4'd15, 4'd15, 5'd16, 6'sd15, 6'sd15},
        '{8'h66, 2'd0, 1'b1, 3'd2, 4'd11, 4'd11, 5'd0,  6'sd11, 6'sd11},
        '{8'h66, 2'd0, 1'b1, 3'd2, 4'd0,  4'd15, 5'd16, 6'sd16, 6'sd15},
        '{8'h68, 2'd0, 1'b1, 3'd2, 4'd15, 4'd15, 5'd0,  6'sd15, 6'sd15},
        '{8'h66, 2'd0, 1'b0, 3'd2, 4'd15, 4'd15, 5'd0,  6'sd15, 6'sd15},
        '{8'h66, 2'd1, 1'b1, 3'd2, 4'd8,  4'd8,  5'd16, 6'sd8,  6'sd8},
        '{8'h66, 2'd1, 1'b1, 3'd2, 4'd7,  4'd7,  5'd0,  6'sd7,  6'sd7},
        '{8'h67, 2'd2, 1'b1, 3'd2, 4'd8,  4'd3,  5'd16, 6'sd8,  6'sd19},
        '{8'h66, 2'd0, 1'b1, 3'd1, 4'd0,  4'd15, 5'd0,  6'sd0,  -6'sd1},
        '{8'h61, 2'd0, 1'b1, 3'd4, 4'd2,  4'd1,  5'd16, 6'sd2,  6'sd17},
        '{8'h66, 2'd3, 1'b1, 3'd2, 4'd9,  4'd9,  5'd0,  6'sd9,  6'sd9}
    };

    // Report one check.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dly(input int p);
        return int'($signed(plane_delay[p*DW +: DW]));
    endfunction

    // Present one line configuration with a single-cycle load strobe.
    task automatic load_line(input logic [7:0] st, input logic [1:0] rm, input logic sw,
                             input logic [2:0] pc, input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        fetch_start = st; res_mode = rm; single_word = sw;
        plane_cnt = pc; pf1_scroll = a; pf2_scroll = b;
        line_load = 1'b1;
        @(negedge clk);
        line_load = 1'b0;
    endtask

    // Present pixel/words and return the colour one edge later.
    task automatic sample(input logic [9:0] px, input logic [15:0] w_even,
                          input logic [15:0] w_odd, output logic [NP-1:0] col);
        @(negedge clk);
        pix_x = px;
        for (int p = 0; p < NP; p++) plane_words[p*WW +: WW] = (p % 2 == 0) ? w_even : w_odd;
        @(negedge clk);
        col = colour_idx;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [NP-1:0] col;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(row_advance == 0, "R1 advance in reset", int'(row_advance), 0);
        check(plane_delay == '0, "R1 delays in reset", dly(0), 0);
        check(colour_idx == '0, "R1 colour in reset", int'(colour_idx), 0);
        rst_n = 1'b1;

        // Vector table: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            load_line(VECS[i].start, VECS[i].res, VECS[i].sw, VECS[i].pc, VECS[i].s1, VECS[i].s2);
            check(row_advance == VECS[i].adv, $sformatf("R4 R6 vec%0d advance", i),
                  int'(row_advance), int'(VECS[i].adv));
            check(dly(0) == int'(VECS[i].d0) && dly(2) == int'(VECS[i].d0),
                  $sformatf("R7 vec%0d even delay", i), dly(0), int'(VECS[i].d0));
            check(dly(1) == int'(VECS[i].d1) && dly(3) == int'(VECS[i].d1),
                  $sformatf("R7 vec%0d odd delay", i), dly(1), int'(VECS[i].d1));
        end

        // R8: sampler, delays 15 on both playfields
        load_line(8'h66, 2'd0, 1'b1, 3'd2, 4'd15, 4'd15);
        sample(10'd15, 16'h8000, 16'h8000, col);
        check(col == 6'b000011, "R8 fetch pixel 0", int'(col), 3);
        sample(10'd14, 16'h8000, 16'h8000, col);
        check(col == 6'b000000, "R8 delay exceeds position", int'(col), 0);
        sample(10'd31, 16'hFFFF, 16'hFFFF, col);
        check(col == 6'b000000, "R8 past word end", int'(col), 0);
        sample(10'd30, 16'h0001, 16'h0000, col);
        check(col == 6'b000001, "R8 last word pixel", int'(col), 1);

        // R9: plane count masks upper planes
        load_line(8'h66, 2'd0, 1'b1, 3'd1, 4'd15, 4'd15);
        sample(10'd15, 16'h8000, 16'h8000, col);
        check(col == 6'b000001, "R9 one plane", int'(col), 1);
        load_line(8'h66, 2'd0, 1'b1, 3'd6, 4'd15, 4'd15);
        sample(10'd15, 16'h8000, 16'h8000, col);
        check(col == 6'b111111, "R9 six planes", int'(col), 63);

        // R8: split playfield delays 16/15
        load_line(8'h66, 2'd0, 1'b1, 3'd2, 4'd0, 4'd15);
        sample(10'd15, 16'h8000, 16'h8000, col);
        check(col == 6'b000010, "R8 split at 15", int'(col), 2);
        sample(10'd16, 16'h8000, 16'h8000, col);
        check(col == 6'b000001, "R8 split at 16", int'(col), 1);

        // R10: colour changes only after the edge
        @(negedge clk);
        pix_x = 10'd15;
        #1;
        check(col == colour_idx, "R10 no change before edge", int'(colour_idx), int'(col));
        @(negedge clk);
        check(colour_idx == 6'b000010, "R10 updated after edge", int'(colour_idx), 2);

        // R2: inputs change without strobe
        @(negedge clk);
        fetch_start = 8'h68; pf1_scroll = 4'd3; pf2_scroll = 4'd3; plane_cnt = 3'd1;
        repeat (3) @(negedge clk);
        check(row_advance == 5'd16, "R2 advance held", int'(row_advance), 16);
        check(dly(0) == 16 && dly(1) == 15, "R2 delays held", dly(0), 16);

        // R1: reset reapplied
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(row_advance == 0 && plane_delay == '0 && colour_idx == '0,
              "R1 reset reapplied", int'(row_advance), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule